// File: doc/BRIEF.md
# Root Hub Change Bitmap Generator

This block builds the status-change bitmap that a root hub returns on its interrupt endpoint. When a start pulse arrives, it visits the root ports one after another through a port-select output and a status-word input. For each port it tests three change flags. Each port that has any of those flags set gets a bit in a two-byte bitmap, and the block reports how many of the two bytes are meaningful.

Bit 0 of the bitmap stands for the hub itself and is never set by a port. Port i (counted from 0) lands on bit i+1. Ports 0 to 6 therefore fill byte 0, and ports 7 to 14 fill byte 1. A length of zero tells the caller that nothing changed, so no transfer is needed. A one-cycle done pulse marks the end of every scan. The bitmap and length then stay put until the next start.

The port count is a parameter from 1 to 15. The status word comes from port registers held elsewhere. The block only reads it.

Top module: `rh_change_map`

## Requirements
- R1: Bitmap bit 0 is never set. A changed port i maps to bitmap bit i+1, which means byte 0 bit i+1 for i below 7, and byte 1 bit i-7 for i of 7 or more (map_o[7:0] is byte 0, map_o[15:8] is byte 1).
- R2: A port counts as changed when status bit 17 (connect change), bit 18 (enable change) or bit 20 (over-current change) is set. All other status bits have no effect on the bitmap.
- R3: When at least one port has changed, the reported length is 2 if NUM_PORTS exceeds 7 and 1 otherwise.
- R4: When no port has changed, the reported length is 0 for any port count.
- R5: The cycle after a start is accepted, scan_active_o goes high. port_sel_o then presents ports 0, 1, ... NUM_PORTS-1, one per cycle, in ascending order.
- R6: A start pulse that arrives while a scan is running is ignored. The running scan neither restarts nor stretches.
- R7: Accepting a start clears the bitmap and the length in the following cycle.
- R8: done_o is high for exactly one cycle: the cycle after the last port is presented. The bitmap and length hold from then until the next accepted start. After reset the outputs are all zero.
- R9: Bitmap bits above bit NUM_PORTS are never set, whatever the status words of unread ports hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted in step with clk_i |
| start_i | input | 1 | Start-of-scan pulse, taken only while idle |
| port_sel_o | output | SEL_W | Index of the port whose status is wanted this cycle |
| port_stat_i | input | STAT_W | Status word of the selected port, valid in the same cycle |
| scan_active_o | output | 1 | High while port_sel_o carries a port being read |
| map_o | output | 16 | Change bitmap, byte 1 in [15:8] and byte 0 in [7:0] |
| len_o | output | 2 | Number of valid bitmap bytes, 0 when nothing changed |
| done_o | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The bench targets the byte boundary first. With a single change on port 6 or port 7, a design that mapped ports without the hub offset, or split the bytes at the wrong port, would set the wrong bit or report a one-byte length where two are needed. Status words carrying only non-change bits, and unread ports with change flags set, show whether a design ORs in the wrong bits or reads past the last port. Starts injected in the middle of a scan, and back-to-back scans where an earlier bitmap was non-zero, expose a design that restarts its counter or carries stale bits into the next report. Two instances, one with more than seven ports and one with fewer, each check their own length rule.

// File: rtl/rhcm_pkg.sv
package rhcm_pkg;

  // Bitmap width: byte 0 plus byte 1
  localparam int unsigned MAP_BITS = 16;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // Number of valid bitmap bytes for a given port count
  function automatic logic [1:0] map_length(input logic any_set,
                                            input int unsigned ports);
    logic [1:0] len;
    if (!any_set)       len = 2'd0;
    else if (ports > 7) len = 2'd2;
    else                len = 2'd1;
    return len;
  endfunction

endpackage

// File: rtl/rhcm_sequencer.sv
module rhcm_sequencer #(
  parameter int unsigned NUM_PORTS = 10,
  parameter int unsigned SEL_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             active_o,
  output logic [SEL_W-1:0] idx_o,
  output logic             begin_o,
  output logic             finish_o
);
  import rhcm_pkg::*;

  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_PORTS - 1);

  scan_state_e      state_q, state_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             at_last;

  assign at_last = (idx_q == LAST_IDX);

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    begin_o  = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      SCAN_IDLE: begin
        if (start_i) begin
          begin_o = 1'b1;
          state_d = SCAN_RUN;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      SCAN_RUN: begin
        if (at_last) begin
          finish_o = 1'b1;
          state_d  = SCAN_IDLE;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCAN_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Port index register with explicit enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign active_o = (state_q == SCAN_RUN);
  assign idx_o    = active_o ? idx_q : '0;

endmodule

// File: rtl/rhcm_flag_detect.sv
module rhcm_flag_detect #(
  parameter int unsigned STAT_W      = 32,
  parameter int unsigned CONN_CHG_BIT = 17,
  parameter int unsigned EN_CHG_BIT   = 18,
  parameter int unsigned OC_CHG_BIT   = 20
) (
  input  logic [STAT_W-1:0] stat_i,
  output logic              hit_o
);

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{CONN_CHG_BIT, EN_CHG_BIT, OC_CHG_BIT};

  logic [STAT_W-1:0] chg_mask;

  // Build the mask of change-flag positions
  always_comb begin
    chg_mask = '0;
    for (int f = 0; f < NUM_FLAGS; f++) begin
      chg_mask[FLAG_POS[f]] = 1'b1;
    end
  end

  assign hit_o = |(stat_i & chg_mask);

endmodule

// File: rtl/rhcm_bitmap_accum.sv
module rhcm_bitmap_accum #(
  parameter int unsigned NUM_PORTS = 10,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned MAP_BITS  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                active_i,
  input  logic [SEL_W-1:0]    idx_i,
  input  logic                hit_i,
  output logic [MAP_BITS-1:0] map_o,
  output logic [MAP_BITS-1:0] map_nxt_o
);

  for (genvar b = 0; b < MAP_BITS; b++) begin : g_bit
    if (b >= 1 && b <= NUM_PORTS) begin : g_port
      // Bitmap bit b belongs to port b-1
      logic bit_q, bit_d, bit_en, set_here;

      assign set_here = active_i && hit_i && (idx_i == SEL_W'(b - 1));

      always_comb begin
        bit_en = clear_i | set_here;
        bit_d  = clear_i ? 1'b0 : 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bit_q <= 1'b0;
        end else if (bit_en) begin
          bit_q <= bit_d;
        end
      end

      assign map_o[b]     = bit_q;
      assign map_nxt_o[b] = bit_en ? bit_d : bit_q;
    end else begin : g_none
      // Hub bit and bits beyond the last port stay zero
      assign map_o[b]     = 1'b0;
      assign map_nxt_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/rh_change_map.sv
module rh_change_map #(
  parameter int unsigned NUM_PORTS    = 10,
  parameter int unsigned STAT_W       = 32,
  parameter int unsigned CONN_CHG_BIT = 17,
  parameter int unsigned EN_CHG_BIT   = 18,
  parameter int unsigned OC_CHG_BIT   = 20,
  localparam int unsigned SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [SEL_W-1:0]  port_sel_o,
  input  logic [STAT_W-1:0] port_stat_i,
  output logic              scan_active_o,
  output logic [15:0]       map_o,
  output logic [1:0]        len_o,
  output logic              done_o
);
  import rhcm_pkg::*;

  logic             active;
  logic [SEL_W-1:0] idx;
  logic             begin_scan;
  logic             finish_scan;
  logic             hit;
  logic [MAP_BITS-1:0] map_q;
  logic [MAP_BITS-1:0] map_nxt;

  logic [1:0] len_q, len_d;
  logic       len_en;
  logic       done_q, done_d;

  rhcm_sequencer #(
    .NUM_PORTS (NUM_PORTS),
    .SEL_W     (SEL_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .active_o (active),
    .idx_o    (idx),
    .begin_o  (begin_scan),
    .finish_o (finish_scan)
  );

  rhcm_flag_detect #(
    .STAT_W       (STAT_W),
    .CONN_CHG_BIT (CONN_CHG_BIT),
    .EN_CHG_BIT   (EN_CHG_BIT),
    .OC_CHG_BIT   (OC_CHG_BIT)
  ) u_det (
    .stat_i (port_stat_i),
    .hit_o  (hit)
  );

  rhcm_bitmap_accum #(
    .NUM_PORTS (NUM_PORTS),
    .SEL_W     (SEL_W),
    .MAP_BITS  (MAP_BITS)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (begin_scan),
    .active_i  (active),
    .idx_i     (idx),
    .hit_i     (hit),
    .map_o     (map_q),
    .map_nxt_o (map_nxt)
  );

  // Length and done: next-state logic
  always_comb begin
    len_en = begin_scan | finish_scan;
    len_d  = begin_scan ? 2'd0 : map_length(|map_nxt, NUM_PORTS);
    done_d = finish_scan;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= 2'd0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign port_sel_o    = idx;
  assign scan_active_o = active;
  assign map_o         = map_q;
  assign len_o         = len_q;
  assign done_o        = done_q;

endmodule

// File: rtl/rh_change_map_sva.sv
module rh_change_map_sva #(
  parameter int unsigned NUM_PORTS = 10,
  parameter int unsigned SEL_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [SEL_W-1:0] port_sel_o,
  input logic             scan_active_o,
  input logic [15:0]      map_o,
  input logic [1:0]       len_o,
  input logic             done_o
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_PORTS - 1);
  localparam logic [1:0]       FULL_LEN = (NUM_PORTS > 7) ? 2'd2 : 2'd1;

  assert_hub_bit_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_o[0] == 1'b0);

  assert_len_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && map_o != 16'd0) |-> len_o == FULL_LEN);

  assert_len_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && map_o == 16'd0) |-> len_o == 2'd0);

  assert_scan_begins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_active_o && start_i) |=> (scan_active_o && port_sel_o == '0));

  assert_select_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_active_o && port_sel_o != LAST_SEL)
      |=> (scan_active_o && port_sel_o == SEL_W'($past(port_sel_o) + 1'b1)));

  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_active_o && start_i) |=> !(scan_active_o && port_sel_o == '0));

  assert_clear_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_active_o && start_i) |=> (map_o == 16'd0 && len_o == 2'd0));

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_active_o && port_sel_o == LAST_SEL) |=> (done_o && !scan_active_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_active_o && !start_i) |=> ($stable(map_o) && $stable(len_o)));

  assert_upper_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_o >> (NUM_PORTS + 1)) == 16'd0);

endmodule

bind rh_change_map rh_change_map_sva #(
  .NUM_PORTS (NUM_PORTS),
  .SEL_W     (SEL_W)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .port_sel_o    (port_sel_o),
  .scan_active_o (scan_active_o),
  .map_o         (map_o),
  .len_o         (len_o),
  .done_o        (done_o)
);

// File: tb/rh_change_map_test.sv
`timescale 1ns/1ps
module rh_change_map_test;

  localparam int NB = 10;  // large instance
  localparam int NS = 5;   // small instance
  localparam logic [31:0] FLAGS = (32'd1 << 17) | (32'd1 << 18) | (32'd1 << 20);

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] stat_mem [16];

  logic [3:0]  sel_b;
  logic [2:0]  sel_s;
  logic        act_b, act_s, done_b, done_s;
  logic [15:0] map_b, map_s;
  logic [1:0]  len_b, len_s;

  int n_checks = 0;
  int n_fail   = 0;

  rh_change_map #(.NUM_PORTS(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .port_sel_o(sel_b), .port_stat_i(stat_mem[sel_b]),
    .scan_active_o(act_b), .map_o(map_b), .len_o(len_b), .done_o(done_b)
  );

  rh_change_map #(.NUM_PORTS(NS)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .port_sel_o(sel_s), .port_stat_i(stat_mem[{1'b0, sel_s}]),
    .scan_active_o(act_s), .map_o(map_s), .len_o(len_s), .done_o(done_s)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_map(input int n);
    logic [15:0] m = '0;
    for (int i = 0; i < n; i++) begin
      if ((stat_mem[i] & FLAGS) != 32'd0) m[i+1] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [1:0] exp_len(input logic [15:0] m, input int n);
    if (m == 16'd0) return 2'd0;
    return (n > 7) ? 2'd2 : 2'd1;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One scan on both instances, checked cycle by cycle
  task automatic run_scan(input string map_req, input bit restart_mid);
    logic [15:0] eb, es;
    logic [1:0]  lb, ls;
    eb = exp_map(NB); lb = exp_len(eb, NB);
    es = exp_map(NS); ls = exp_len(es, NS);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c <= NB + 1; c++) begin
      if (c > 0) @(negedge clk);
      start = (restart_mid && c == 2) ? 1'b1 : 1'b0;
      if (c == 0) begin
        chk("R7", "big clear", {14'd0, len_b, map_b}, 32'd0);
        chk("R7", "small clear", {14'd0, len_s, map_s}, 32'd0);
      end
      if (c < NB)
        chk(restart_mid ? "R6" : "R5", "big select", {act_b, done_b, sel_b}, {1'b1, 1'b0, 4'(c)});
      else if (c == NB) begin
        chk("R8", "big done", {act_b, done_b}, 2'b01);
        chk(map_req, "big map", map_b, eb);
        chk(lb == 2'd0 ? "R4" : "R3", "big len", len_b, lb);
      end else begin
        chk("R8", "big done drop/hold", {done_b, len_b, map_b}, {1'b0, lb, eb});
      end
      if (c < NS)
        chk(restart_mid ? "R6" : "R5", "small select", {act_s, done_s, sel_s}, {1'b1, 1'b0, 3'(c)});
      else if (c == NS) begin
        chk("R8", "small done", {act_s, done_s}, 2'b01);
        chk(map_req, "small map", map_s, es);
        chk("R9", "small upper bits", map_s >> (NS + 1), 32'd0);
        chk(ls == 2'd0 ? "R4" : "R3", "small len", len_s, ls);
      end else if (c == NS + 1) begin
        chk("R8", "small done drop/hold", {done_s, len_s, map_s}, {1'b0, ls, es});
      end
    end
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "big hold idle", {len_b, map_b}, {lb, eb});
    chk("R8", "small hold idle", {len_s, map_s}, {ls, es});
  endtask

  task automatic clear_stats();
    for (int i = 0; i < 16; i++) stat_mem[i] = 32'd0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL R5 watchdog: actual running expected finished");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    start = 1'b0;
    clear_stats();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "reset state big", {act_b, done_b, len_b, map_b}, 32'd0);
    chk("R8", "reset state small", {act_s, done_s, len_s, map_s}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Nothing changed anywhere
    run_scan("R4", 1'b0);

    // Only non-change bits set: must be ignored
    for (int i = 0; i < 16; i++) stat_mem[i] = ~FLAGS;
    run_scan("R2", 1'b0);

    // Byte boundary: port 6 (byte 0 bit 7) then port 7 (byte 1 bit 0)
    clear_stats(); stat_mem[6] = 32'd1 << 17;
    run_scan("R1", 1'b0);
    clear_stats(); stat_mem[7] = 32'd1 << 20;
    run_scan("R1", 1'b0);

    // Each change flag alone on port 0
    clear_stats(); stat_mem[0] = 32'd1 << 18;
    run_scan("R2", 1'b0);
    clear_stats(); stat_mem[0] = 32'd1 << 20;
    run_scan("R2", 1'b0);

    // All ports changed, restart attempt mid-scan
    for (int i = 0; i < 16; i++) stat_mem[i] = FLAGS;
    run_scan("R1", 1'b1);

    // Unread ports only: small instance must stay empty
    clear_stats(); stat_mem[5] = FLAGS; stat_mem[9] = 32'd1 << 17;
    run_scan("R9", 1'b0);

    // Constrained random
    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < 16; i++) begin
        stat_mem[i] = $urandom;
        if (($urandom % 3) != 0) stat_mem[i] = stat_mem[i] & ~FLAGS;
      end
      run_scan("R1", ($urandom % 4) == 0);
    end

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule